// File: doc/BRIEF.md
# Floating-Point Special-Operand and Exception Unit

This block sits next to the arithmetic datapath of a binary32 add, subtract, multiply and divide unit. It handles the operands that ordinary arithmetic cannot handle. On each valid strobe it sorts both operands into zero, subnormal, normal, infinity, quiet NaN or signaling NaN. When the combination decides the answer without any arithmetic, the block produces that answer itself and tells the datapath to discard its own. Such combinations are a NaN input, an infinity input, a division by zero or an undefined form. The block raises invalid-operation and division-by-zero itself.

Five sticky exception flags collect those two events together with the overflow, underflow and inexact conditions that the datapath reports on the same strobe. Software reads the flags at any time and clears them through a mask. A per-exception enable register selects trapping. Every enable comes out of reset cleared, so computation continues with the default special result, and no trap is requested unless software asks for one. All outputs are registered and appear one clock after the strobe.

Top module: `fp_special_unit`

## Requirements
- R1: Operands use sign bit 31, exponent bits 30:23 and fraction bits 22:0. `op_code` is 00 add, 01 subtract, 10 multiply and 11 divide. `res_valid`, `bypass` and `result` reflect the operation strobed one clock earlier.
- R2: A divide with a subnormal or normal dividend and a zero divisor gives an infinity whose sign is the XOR of the two operand signs, with bypass and the divide-by-zero flag set. The sign of the zero divisor counts.
- R3: The following give the default NaN 0x7FC00000 and set the invalid flag: zero divided by zero, infinity divided by infinity, zero times infinity in either order, and an effective subtraction of two infinities of the same sign. The last one is addition of opposite-signed infinities or subtraction of like-signed ones.
- R4: These give an exact result with no flag: finite times infinity, finite plus or minus infinity, an effective addition of like-signed infinities, and infinity divided by a finite value. Each gives a correctly signed infinity. A finite value divided by infinity gives a signed zero, also with no flag.
- R5: Any NaN operand gives a NaN. The result is operand a if it is a NaN, otherwise operand b, with fraction bit 22 forced to 1. Fraction bit 22 equal to 0 marks a signaling NaN. Any signaling NaN operand sets invalid, and quiet NaNs alone set no flag.
- R6: The flag bits are: 0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid. A flag sets on an event and stays set until a clear with `clr_valid` names it in `clr_mask`. An event in the same cycle as its clear leaves the flag set.
- R7: When no special case applies, the datapath's `dp_ovf`, `dp_unf` and `dp_inx` inputs are ORed into their flags on the strobe. When the block bypasses the datapath, these inputs are ignored.
- R8: Trap enables (same bit order as the flags) reset to zero and load from `trap_en_data` when `trap_en_wr` is high. `trap_req` is high for exactly one cycle after an operation that raises an enabled exception.
- R9: After reset, `sticky_flags`, `trap_en`, `res_valid`, `bypass` and `trap_req` are all zero.
- R10: An operation with no special case returns `bypass` low and `result` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | Operation select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| dp_ovf | input | 1 | Datapath overflow condition |
| dp_unf | input | 1 | Datapath underflow condition |
| dp_inx | input | 1 | Datapath inexact condition |
| clr_valid | input | 1 | Apply flag clear |
| clr_mask | input | 5 | Flags to clear |
| trap_en_wr | input | 1 | Load trap enables |
| trap_en_data | input | 5 | New trap enables |
| res_valid | output | 1 | Registered result valid |
| bypass | output | 1 | Special result overrides datapath |
| result | output | 32 | Special-case result |
| sticky_flags | output | 5 | Accumulated exception flags |
| trap_en | output | 5 | Trap enable register |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The main function is tried with the following inputs:
- Signed zeros of both polarities as divisors, so that a lost divisor sign shows up directly in the infinity.
- Each undefined form paired with a neighbour that differs only in an operand sign or the operation. For example, infinity minus negative infinity sits beside infinity minus infinity, which separates the effective-subtraction test from a plain sign compare.
- A signaling NaN in either operand slot, and a quiet NaN ahead of a signaling one. These show whether NaN selection order and the invalid flag are decided separately.
- Datapath conditions presented both with and without a special case. This tells merging apart from ignoring.
- Flag-clear collisions and trap-enable subsets. These separate sticky accumulation from per-operation reporting.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int NFLAG  = 5;

  // flag bit positions
  localparam int FL_NX = 0;
  localparam int FL_UF = 1;
  localparam int FL_OF = 2;
  localparam int FL_DZ = 3;
  localparam int FL_NV = 4;

  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_SUB = 2'b01;
  localparam logic [1:0] OP_MUL = 2'b10;
  localparam logic [1:0] OP_DIV = 2'b11;

  localparam logic [WORD_W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [2:0] {
    CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
  } fcls_e;
endpackage

// File: rtl/fpx_classify.sv
module fpx_classify
  import fpx_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW+FW:0] val,
  output fcls_e          cls
);
  logic [EW-1:0] ex;
  logic [FW-1:0] fr;

  assign ex = val[EW+FW-1:FW];
  assign fr = val[FW-1:0];

  always_comb begin
    if (ex == '0)
      cls = (fr == '0) ? CL_ZERO : CL_SUB;
    else if (ex == '1) begin
      if (fr == '0)       cls = CL_INF;
      else if (fr[FW-1])  cls = CL_QNAN;
      else                cls = CL_SNAN;
    end else
      cls = CL_NORM;
  end
endmodule

// File: rtl/fpx_resolve.sv
module fpx_resolve
  import fpx_pkg::*;
(
  input  logic [1:0]        op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  fcls_e             cls_a,
  input  fcls_e             cls_b,
  output logic              special,
  output logic [WORD_W-1:0] res,
  output logic              nv,
  output logic              dz
);
  localparam logic [EXP_W-1:0] EMAX = '1;

  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, a_fin, b_fin;
  logic sa, sb, sb_eff, sx;
  logic [WORD_W-1:0] nan_src;

  assign a_nan  = (cls_a == CL_QNAN) || (cls_a == CL_SNAN);
  assign b_nan  = (cls_b == CL_QNAN) || (cls_b == CL_SNAN);
  assign a_inf  = (cls_a == CL_INF);
  assign b_inf  = (cls_b == CL_INF);
  assign a_zero = (cls_a == CL_ZERO);
  assign b_zero = (cls_b == CL_ZERO);
  assign a_fin  = (cls_a == CL_SUB) || (cls_a == CL_NORM);
  assign b_fin  = (cls_b == CL_SUB) || (cls_b == CL_NORM);
  assign sa     = a[WORD_W-1];
  assign sb     = b[WORD_W-1];
  assign sb_eff = sb ^ (op == OP_SUB);
  assign sx     = sa ^ sb;
  assign nan_src = a_nan ? a : b;

  always_comb begin
    special = 1'b0;
    res     = '0;
    nv      = 1'b0;
    dz      = 1'b0;
    if (a_nan || b_nan) begin
      special = 1'b1;
      res     = {nan_src[WORD_W-1:FRAC_W], 1'b1, nan_src[FRAC_W-2:0]};
      nv      = (cls_a == CL_SNAN) || (cls_b == CL_SNAN);
    end else begin
      unique case (op)
        OP_ADD, OP_SUB: begin
          if (a_inf && b_inf && (sa != sb_eff)) begin
            special = 1'b1; res = DEF_NAN; nv = 1'b1;
          end else if (a_inf) begin
            special = 1'b1; res = {sa, EMAX, {FRAC_W{1'b0}}};
          end else if (b_inf) begin
            special = 1'b1; res = {sb_eff, EMAX, {FRAC_W{1'b0}}};
          end
        end
        OP_MUL: begin
          if ((a_zero && b_inf) || (a_inf && b_zero)) begin
            special = 1'b1; res = DEF_NAN; nv = 1'b1;
          end else if (a_inf || b_inf) begin
            special = 1'b1; res = {sx, EMAX, {FRAC_W{1'b0}}};
          end
        end
        default: begin
          if ((a_zero && b_zero) || (a_inf && b_inf)) begin
            special = 1'b1; res = DEF_NAN; nv = 1'b1;
          end else if (a_fin && b_zero) begin
            special = 1'b1; res = {sx, EMAX, {FRAC_W{1'b0}}}; dz = 1'b1;
          end else if (a_inf) begin
            special = 1'b1; res = {sx, EMAX, {FRAC_W{1'b0}}};
          end else if (b_inf) begin
            special = 1'b1; res = {sx, {(WORD_W-1){1'b0}}};
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fpx_flags.sv
module fpx_flags
  import fpx_pkg::*;
#(
  parameter int NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [NF-1:0] evt,
  input  logic          clr_valid,
  input  logic [NF-1:0] clr_mask,
  input  logic          en_wr,
  input  logic [NF-1:0] en_data,
  output logic [NF-1:0] sticky,
  output logic [NF-1:0] en,
  output logic          trap
);
  logic [NF-1:0] sticky_q, sticky_d, en_q, en_d, raised;
  logic          trap_q, trap_d;

  assign raised = evt_valid ? evt : '0;

  always_comb begin
    sticky_d = sticky_q;
    if (clr_valid) sticky_d = sticky_d & ~clr_mask;
    sticky_d = sticky_d | raised;   // new event wins over clear
    en_d     = en_wr ? en_data : en_q;
    trap_d   = |(raised & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      en_q     <= '0;
      trap_q   <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      en_q     <= en_d;
      trap_q   <= trap_d;
    end
  end

  assign sticky = sticky_q;
  assign en     = en_q;
  assign trap   = trap_q;
endmodule

// File: rtl/fp_special_unit.sv
module fp_special_unit
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic              dp_ovf,
  input  logic              dp_unf,
  input  logic              dp_inx,
  input  logic              clr_valid,
  input  logic [NFLAG-1:0]  clr_mask,
  input  logic              trap_en_wr,
  input  logic [NFLAG-1:0]  trap_en_data,
  output logic              res_valid,
  output logic              bypass,
  output logic [WORD_W-1:0] result,
  output logic [NFLAG-1:0]  sticky_flags,
  output logic [NFLAG-1:0]  trap_en,
  output logic              trap_req
);
  localparam int NOPND = 2;

  logic [NOPND-1:0][WORD_W-1:0] opnd;
  fcls_e                        cls [NOPND];

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar i = 0; i < NOPND; i++) begin : g_cls
    fpx_classify #(.EW(EXP_W), .FW(FRAC_W)) u_cls (
      .val (opnd[i]),
      .cls (cls[i])
    );
  end

  logic              spec, nv, dz;
  logic [WORD_W-1:0] spec_res;

  fpx_resolve u_res (
    .op      (op_code),
    .a       (opnd_a),
    .b       (opnd_b),
    .cls_a   (cls[0]),
    .cls_b   (cls[1]),
    .special (spec),
    .res     (spec_res),
    .nv      (nv),
    .dz      (dz)
  );

  logic [NFLAG-1:0] evt;
  always_comb begin
    evt        = '0;
    evt[FL_NV] = nv;
    evt[FL_DZ] = dz;
    evt[FL_OF] = dp_ovf & ~spec;
    evt[FL_UF] = dp_unf & ~spec;
    evt[FL_NX] = dp_inx & ~spec;
  end

  fpx_flags #(.NF(NFLAG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (op_valid),
    .evt       (evt),
    .clr_valid (clr_valid),
    .clr_mask  (clr_mask),
    .en_wr     (trap_en_wr),
    .en_data   (trap_en_data),
    .sticky    (sticky_flags),
    .en        (trap_en),
    .trap      (trap_req)
  );

  logic              vld_q, vld_d, byp_q, byp_d;
  logic [WORD_W-1:0] res_q, res_d;

  always_comb begin
    vld_d = op_valid;
    byp_d = op_valid & spec;
    res_d = spec ? spec_res : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      byp_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      byp_q <= byp_d;
      if (op_valid) res_q <= res_d;
    end
  end

  assign res_valid = vld_q;
  assign bypass    = byp_q;
  assign result    = res_q;
endmodule

// File: rtl/fpx_special_chk.sv
module fpx_special_chk
  import fpx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              clr_valid,
  input logic [NFLAG-1:0]  clr_mask,
  input logic              res_valid,
  input logic              bypass,
  input logic [WORD_W-1:0] result,
  input logic [NFLAG-1:0]  sticky_flags,
  input logic [NFLAG-1:0]  trap_en,
  input logic              trap_req
);
  // R1: output valid follows the strobe by one clock
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(op_valid));

  // R10: bypass only accompanies a valid result
  a_r10_bypass_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> res_valid);

  // R5: a NaN result from the special path is always quiet
  a_r5_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && result[WORD_W-2:FRAC_W] == '1 && result[FRAC_W-1:0] != '0)
      |-> result[FRAC_W-1]);

  // R6: a set flag survives unless a clear named it
  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(sticky_flags) & ~($past(clr_valid) ? $past(clr_mask) : '0))
      & ~sticky_flags) == '0));

  // R8: no trap without an enable in the cycle of the event
  a_r8_no_trap_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trap_en) == '0) |-> !trap_req);

  // R8: a trap follows an operation
  a_r8_trap_after_op: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> res_valid);
endmodule

bind fp_special_unit fpx_special_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .clr_valid    (clr_valid),
  .clr_mask     (clr_mask),
  .res_valid    (res_valid),
  .bypass       (bypass),
  .result       (result),
  .sticky_flags (sticky_flags),
  .trap_en      (trap_en),
  .trap_req     (trap_req)
);

// File: tb/fp_special_unit_tb.sv
module fp_special_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 22;

  logic        clk, rst_n;
  logic        op_valid;
  logic [1:0]  op_code;
  logic [31:0] opnd_a, opnd_b;
  logic        dp_ovf, dp_unf, dp_inx;
  logic        clr_valid;
  logic [4:0]  clr_mask;
  logic        trap_en_wr;
  logic [4:0]  trap_en_data;
  logic        res_valid, bypass, trap_req;
  logic [31:0] result;
  logic [4:0]  sticky_flags, trap_en;

  int checks = 0;
  int errors = 0;

  fp_special_unit dut_i (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // op, a, b, dp{ovf,unf,inx}, bypass, result, flags{nv,dz,of,uf,nx}, req
  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  dp;
    logic        byp;
    logic [31:0] res;
    logic [4:0]  fl;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{2'd3, 32'h3F800000, 32'h00000000, 3'b000, 1'b1, 32'h7F800000, 5'b01000, 8'd2}, // R2 1/+0
    '{2'd3, 32'h3F800000, 32'h80000000, 3'b000, 1'b1, 32'hFF800000, 5'b01000, 8'd2}, // R2 1/-0
    '{2'd3, 32'hC0000000, 32'h80000000, 3'b000, 1'b1, 32'h7F800000, 5'b01000, 8'd2}, // R2 -2/-0
    '{2'd3, 32'h00000001, 32'h00000000, 3'b000, 1'b1, 32'h7F800000, 5'b01000, 8'd2}, // R2 sub/+0
    '{2'd3, 32'h00000000, 32'h80000000, 3'b000, 1'b1, 32'h7FC00000, 5'b10000, 8'd3}, // R3 0/0
    '{2'd1, 32'h7F800000, 32'h7F800000, 3'b000, 1'b1, 32'h7FC00000, 5'b10000, 8'd3}, // R3 inf-inf
    '{2'd0, 32'h7F800000, 32'hFF800000, 3'b000, 1'b1, 32'h7FC00000, 5'b10000, 8'd3}, // R3 inf+-inf
    '{2'd1, 32'h7F800000, 32'hFF800000, 3'b000, 1'b1, 32'h7F800000, 5'b00000, 8'd4}, // R4 inf--inf
    '{2'd3, 32'hFF800000, 32'h7F800000, 3'b000, 1'b1, 32'h7FC00000, 5'b10000, 8'd3}, // R3 inf/inf
    '{2'd2, 32'h00000000, 32'hFF800000, 3'b000, 1'b1, 32'h7FC00000, 5'b10000, 8'd3}, // R3 0*inf
    '{2'd2, 32'hFF800000, 32'h80000000, 3'b000, 1'b1, 32'h7FC00000, 5'b10000, 8'd3}, // R3 inf*0
    '{2'd2, 32'hC0000000, 32'h7F800000, 3'b000, 1'b1, 32'hFF800000, 5'b00000, 8'd4}, // R4 -2*inf
    '{2'd0, 32'h3F800000, 32'hFF800000, 3'b000, 1'b1, 32'hFF800000, 5'b00000, 8'd4}, // R4 1+-inf
    '{2'd1, 32'h3F800000, 32'hFF800000, 3'b000, 1'b1, 32'h7F800000, 5'b00000, 8'd4}, // R4 1--inf
    '{2'd0, 32'hFF800000, 32'hFF800000, 3'b000, 1'b1, 32'hFF800000, 5'b00000, 8'd4}, // R4 -inf+-inf
    '{2'd3, 32'hC0000000, 32'h7F800000, 3'b000, 1'b1, 32'h80000000, 5'b00000, 8'd4}, // R4 -2/inf
    '{2'd0, 32'h7F800001, 32'h3F800000, 3'b000, 1'b1, 32'h7FC00001, 5'b10000, 8'd5}, // R5 sNaN a
    '{2'd2, 32'h3F800000, 32'hFFC12345, 3'b000, 1'b1, 32'hFFC12345, 5'b00000, 8'd5}, // R5 qNaN b
    '{2'd3, 32'hFFC12345, 32'h7F800001, 3'b000, 1'b1, 32'hFFC12345, 5'b10000, 8'd5}, // R5 q then s
    '{2'd0, 32'h3F800000, 32'h3F800000, 3'b101, 1'b0, 32'h00000000, 5'b00101, 8'd7}, // R7 ovf+inx
    '{2'd0, 32'h7F800000, 32'h3F800000, 3'b010, 1'b1, 32'h7F800000, 5'b00000, 8'd7}, // R7 ignored
    '{2'd2, 32'h3F800000, 32'h3F800000, 3'b010, 1'b0, 32'h00000000, 5'b00010, 8'd10} // R10 normal
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0;
    dp_ovf = 0; dp_unf = 0; dp_inx = 0;
    clr_valid = 0; clr_mask = 0; trap_en_wr = 0; trap_en_data = 0;
  endtask

  // drive one operation on a falling edge; outputs are sampled at the next falling edge
  task automatic do_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] dp, input logic clr, input logic [4:0] cm);
    @(negedge clk);
    op_valid = 1; op_code = op; opnd_a = a; opnd_b = b;
    {dp_ovf, dp_unf, dp_inx} = dp;
    clr_valid = clr; clr_mask = cm;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic set_en(input logic [4:0] v);
    @(negedge clk);
    trap_en_wr = 1; trap_en_data = v;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_valid = 1; clr_mask = 5'h1F;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9 reset state
    check("R9", "sticky", {27'b0, sticky_flags}, 32'h0);
    check("R9", "trap_en", {27'b0, trap_en}, 32'h0);
    check("R9", "res_valid", {31'b0, res_valid}, 32'h0);
    check("R9", "bypass", {31'b0, bypass}, 32'h0);
    check("R9", "trap_req", {31'b0, trap_req}, 32'h0);

    // R8 default enables are zero: invalid raises no trap
    do_op(2'd3, 32'h0, 32'h0, 3'b000, 1'b0, 5'h0);
    check("R8", "trap with enables clear", {31'b0, trap_req}, 32'h0);
    check("R6", "invalid sticky", {27'b0, sticky_flags}, 32'h10);

    // R6 flag holds across an operation with no event, then accumulates
    do_op(2'd0, 32'h3F800000, 32'h3F800000, 3'b000, 1'b0, 5'h0);
    check("R6", "hold", {27'b0, sticky_flags}, 32'h10);
    do_op(2'd3, 32'h3F800000, 32'h0, 3'b000, 1'b0, 5'h0);
    check("R6", "accumulate", {27'b0, sticky_flags}, 32'h18);
    // R6 masked clear removes only divide-by-zero
    @(negedge clk); clr_valid = 1; clr_mask = 5'b01000;
    @(negedge clk); idle_inputs();
    check("R6", "partial clear", {27'b0, sticky_flags}, 32'h10);
    // R6 clear and new invalid together: invalid stays
    do_op(2'd3, 32'h0, 32'h0, 3'b000, 1'b1, 5'b10000);
    check("R6", "event beats clear", {27'b0, sticky_flags}, 32'h10);

    // R8 enable only divide-by-zero
    set_en(5'b01000);
    check("R8", "enable readback", {27'b0, trap_en}, 32'h08);
    do_op(2'd2, 32'h0, 32'h7F800000, 3'b000, 1'b1, 5'h1F);
    check("R8", "masked invalid no trap", {31'b0, trap_req}, 32'h0);
    do_op(2'd3, 32'h3F800000, 32'h80000000, 3'b000, 1'b0, 5'h0);
    check("R8", "enabled dz traps", {31'b0, trap_req}, 32'h1);
    @(negedge clk);
    check("R8", "trap one cycle", {31'b0, trap_req}, 32'h0);
    check("R1", "valid drops", {31'b0, res_valid}, 32'h0);

    // table walk with all traps enabled and flags cleared on each strobe
    set_en(5'h1F);
    clear_all();
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VT[i].req, i);
      do_op(VT[i].op, VT[i].a, VT[i].b, VT[i].dp, 1'b1, 5'h1F);
      check(tag, "res_valid", {31'b0, res_valid}, 32'h1);
      check(tag, "bypass", {31'b0, bypass}, {31'b0, VT[i].byp});
      if (VT[i].byp) check(tag, "result", result, VT[i].res);
      else           check(tag, "result", result, 32'h0);
      check(tag, "flags", {27'b0, sticky_flags}, {27'b0, VT[i].fl});
      check(tag, "trap", {31'b0, trap_req}, {31'b0, (VT[i].fl != 5'b0)});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule